// File: doc/BRIEF.md
# PHY Init Sequence Interpreter

This block brings an external PHY into a known configuration with no software involved. On a start strobe it soft-resets the PHY over a management register port. It reads the PHY control register, writes it back with the reset bit set, and polls until the PHY clears that bit. It then reads a pointer from a fixed word of a 16-bit word-addressed configuration ROM and walks the ID list found there to locate the init block for the requested module type. Finally it interprets that block word by word. Each word can cause a millisecond delay, a burst of register writes to consecutive PHY registers, or a control action that either ends the sequence or lets it continue.

Both external ports are request/response channels. A request is offered with a valid signal and is accepted on a clock edge where ready is also high. Until that edge the block holds valid, the address, the write flag and the write data unchanged. The block waits for acceptance indefinitely, so the far side may apply back-pressure for any number of cycles. A read is answered by a single-cycle response valid pulse that carries the data. The block always accepts that pulse and never has more than one request outstanding across both ports. Writes have no response.

When the sequence ends, `done` goes high. One of two flags may go high with it: `error` for a protocol or content fault, or `not_supported` when there is no usable block for the module type. All three hold until the next accepted start.

Top module: `phyinit_engine`

## Requirements
- R1: After reset, done, error and not_supported are low and neither port has a request pending.
- R2: A start first issues a management read of PHY_CTRL_REG. It then writes back the value read with bit 15 set, and polls PHY_CTRL_REG with reads until bit 15 reads back as 0.
- R3: If POLL_MAX polls after the reset write all return bit 15 set, the block ends with done and error, and makes no ROM access.
- R4: The list pointer is read from ROM word LIST_PTR_ADDR. A pointer of 0x0000 or 0xFFFF ends the sequence with done and error.
- R5: The ID list starts at pointer+1 and holds pairs of words: an ID word followed by a data-offset word. The block compares each ID word with the (remapped) module type. The ID 0xFFFF marks the end of the list, and reaching it ends the sequence with done and not_supported.
- R6: A matched data offset of 0x0000 or 0xFFFF ends the sequence with done and not_supported.
- R7: Before the lookup, module types 5 and 7 are replaced by 3, types 6 and 8 are replaced by 4, and every other type is used as given.
- R8: The word at the data offset is a check word and is skipped; interpretation starts at offset+1. Each interpreted word carries a kind in bits 15:12 and an argument in bits 11:0.
- R9: Kind 0x0 waits for argument × (CLK_HZ/1000) clock cycles and issues no requests during the wait.
- R10: Kind 0x1 reads the next word as a PHY register address A. It then reads the following N words (N being the argument) and writes them to registers A, A+1, …, A+N-1 in order. N = 0 writes nothing.
- R11: Kind 0xF with argument 0xFFF ends the sequence with done only. Kind 0xF with argument 0x000 continues with the next word. Kind 0xF with any other argument, or any other kind, ends the sequence with done and error.
- R12: A start is ignored while a sequence runs. The outcome outputs hold until the next accepted start, and that start clears them.
- R13: A request is held stable until accepted, and at most one request is outstanding across both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, accepted when not running |
| module_type | input | TYPE_W | Module type code to look up |
| done | output | 1 | Sequence finished (any outcome) |
| error | output | 1 | Finished with a fault |
| not_supported | output | 1 | Finished without a usable block |
| rom_req_valid | output | 1 | ROM read request valid |
| rom_req_ready | input | 1 | ROM read request accepted |
| rom_addr | output | ADDR_W | ROM word address |
| rom_rsp_valid | input | 1 | ROM read data valid (one cycle) |
| rom_rsp_data | input | 16 | ROM read data |
| mgmt_req_valid | output | 1 | Management request valid |
| mgmt_req_ready | input | 1 | Management request accepted |
| mgmt_write | output | 1 | 1 = register write, 0 = register read |
| mgmt_addr | output | ADDR_W | PHY register address |
| mgmt_wdata | output | 16 | Register write data |
| mgmt_rsp_valid | input | 1 | Management read data valid (one cycle) |
| mgmt_rsp_data | input | 16 | Management read data |

## Verification
The assertions assume three things about the far side of each port. A response pulse arrives only after the block's own read request was accepted. It arrives exactly once per read. A write never produces one. The bench models both ports this way. It answers an accepted read on the following cycle and never otherwise, and it stretches ready low on a fixed pattern to exercise back-pressure. Start is pulsed for a single cycle, and one extra pulse is deliberately issued mid-run to exercise the ignore rule.

// File: rtl/phyinit_pkg.sv
package phyinit_pkg;

  localparam int WORD_W = 16;
  localparam int KIND_W = 4;
  localparam int ARG_W  = WORD_W - KIND_W;

  localparam logic [KIND_W-1:0] KIND_WAIT  = 4'h0;
  localparam logic [KIND_W-1:0] KIND_BURST = 4'h1;
  localparam logic [KIND_W-1:0] KIND_CTL   = 4'hF;
  localparam logic [ARG_W-1:0]  ARG_FINISH = 12'hFFF;
  localparam logic [ARG_W-1:0]  ARG_GOON   = 12'h000;
  localparam logic [WORD_W-1:0] LIST_STOP  = 16'hFFFF;

  typedef enum logic [2:0] {
    OP_WAIT, OP_BURST, OP_FINISH, OP_GOON, OP_BAD
  } op_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_MRD, ST_MRD_W, ST_MWR, ST_RRD, ST_RRD_W, ST_DLY, ST_DONE
  } state_t;

  typedef enum logic [2:0] {
    PH_CAP, PH_POLL, PH_PTR, PH_ID, PH_OFS, PH_CMD, PH_REG, PH_DATA
  } phase_t;

  // Port-equivalent module types share the short/long-reach block.
  function automatic logic [WORD_W-1:0] remap_type(input logic [WORD_W-1:0] t);
    case (t)
      16'd5, 16'd7: remap_type = 16'd3;
      16'd6, 16'd8: remap_type = 16'd4;
      default:      remap_type = t;
    endcase
  endfunction

  function automatic logic is_blank(input logic [WORD_W-1:0] w);
    is_blank = (w == '0) || (w == '1);
  endfunction

endpackage

// File: rtl/phyinit_word_decode.sv
module phyinit_word_decode
  import phyinit_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output op_t               op,
  output logic [ARG_W-1:0]  arg
);
  logic [KIND_W-1:0] kind;

  assign kind = word[WORD_W-1 -: KIND_W];
  assign arg  = word[ARG_W-1:0];

  always_comb begin
    unique case (kind)
      KIND_WAIT:  op = OP_WAIT;
      KIND_BURST: op = OP_BURST;
      KIND_CTL: begin
        if (arg == ARG_FINISH)    op = OP_FINISH;
        else if (arg == ARG_GOON) op = OP_GOON;
        else                      op = OP_BAD;
      end
      default:    op = OP_BAD;
    endcase
  end
endmodule

// File: rtl/phyinit_ms_timer.sv
module phyinit_ms_timer #(
  parameter int CLK_HZ = 200_000_000,
  parameter int CNT_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] ms_in,
  output logic             expired
);
  localparam int PRE   = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
  localparam int PRE_W = $clog2(PRE + 1);

  logic [CNT_W-1:0] ms_left;
  logic [PRE_W-1:0] pre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_left <= '0;
      pre     <= '0;
    end else if (load) begin
      ms_left <= ms_in;
      pre     <= '0;
    end else if (ms_left != '0) begin
      if (pre == PRE_W'(PRE - 1)) begin
        pre     <= '0;
        ms_left <= ms_left - 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  assign expired = (ms_left == '0);

  // R9: prescaler never leaves its range
  p_pre_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pre < PRE_W'(PRE));
  // R9: a running count only moves down, one millisecond at a time
  p_ms_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load && ms_left != '0 |=> ms_left == $past(ms_left) || ms_left == $past(ms_left) - 1'b1);
endmodule

// File: rtl/phyinit_engine.sv
module phyinit_engine
  import phyinit_pkg::*;
#(
  parameter int                 CLK_HZ        = 200_000_000,
  parameter int                 POLL_MAX      = 100,
  parameter int                 ADDR_W        = 16,
  parameter int                 TYPE_W        = 8,
  parameter logic [ADDR_W-1:0]  LIST_PTR_ADDR = 16'h0010,
  parameter logic [ADDR_W-1:0]  PHY_CTRL_REG  = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TYPE_W-1:0] module_type,
  output logic              done,
  output logic              error,
  output logic              not_supported,
  output logic              rom_req_valid,
  input  logic              rom_req_ready,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic              rom_rsp_valid,
  input  logic [WORD_W-1:0] rom_rsp_data,
  output logic              mgmt_req_valid,
  input  logic              mgmt_req_ready,
  output logic              mgmt_write,
  output logic [ADDR_W-1:0] mgmt_addr,
  output logic [WORD_W-1:0] mgmt_wdata,
  input  logic              mgmt_rsp_valid,
  input  logic [WORD_W-1:0] mgmt_rsp_data
);
  localparam int POLL_W  = $clog2(POLL_MAX + 1);
  localparam int RST_BIT = WORD_W - 1;

  state_t            st;
  phase_t            ph;
  logic [ADDR_W-1:0] rom_a, reg_a;
  logic [ARG_W-1:0]  left;
  logic [WORD_W-1:0] wdata_q, mtype_q;
  logic [POLL_W-1:0] poll_cnt;
  logic              done_q, err_q, ns_q;

  op_t              op;
  logic [ARG_W-1:0] arg;
  logic             tmr_load, tmr_expired;

  phyinit_word_decode u_dec (
    .word (rom_rsp_data),
    .op   (op),
    .arg  (arg)
  );

  assign tmr_load = (st == ST_RRD_W) && rom_rsp_valid && (ph == PH_CMD) && (op == OP_WAIT);

  phyinit_ms_timer #(.CLK_HZ(CLK_HZ), .CNT_W(ARG_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .ms_in   (arg),
    .expired (tmr_expired)
  );

  assign rom_req_valid  = (st == ST_RRD);
  assign rom_addr       = rom_a;
  assign mgmt_req_valid = (st == ST_MRD) || (st == ST_MWR);
  assign mgmt_write     = (st == ST_MWR);
  assign mgmt_addr      = (ph == PH_CAP || ph == PH_POLL) ? PHY_CTRL_REG : reg_a;
  assign mgmt_wdata     = wdata_q;
  assign done           = done_q;
  assign error          = err_q;
  assign not_supported  = ns_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ph       <= PH_CAP;
      rom_a    <= '0;
      reg_a    <= '0;
      left     <= '0;
      wdata_q  <= '0;
      mtype_q  <= '0;
      poll_cnt <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      ns_q     <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            mtype_q  <= remap_type(WORD_W'(module_type));
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            ns_q     <= 1'b0;
            poll_cnt <= '0;
            ph       <= PH_CAP;
            st       <= ST_MRD;
          end
        end
        ST_MRD: if (mgmt_req_ready) st <= ST_MRD_W;
        ST_MRD_W: begin
          if (mgmt_rsp_valid) begin
            if (ph == PH_CAP) begin
              wdata_q <= mgmt_rsp_data | (WORD_W'(1) << RST_BIT);
              st      <= ST_MWR;
            end else if (!mgmt_rsp_data[RST_BIT]) begin
              rom_a <= LIST_PTR_ADDR;
              ph    <= PH_PTR;
              st    <= ST_RRD;
            end else if (poll_cnt == POLL_W'(POLL_MAX - 1)) begin
              err_q  <= 1'b1;
              done_q <= 1'b1;
              st     <= ST_DONE;
            end else begin
              poll_cnt <= poll_cnt + 1'b1;
              st       <= ST_MRD;
            end
          end
        end
        ST_MWR: begin
          if (mgmt_req_ready) begin
            if (ph == PH_CAP) begin
              ph <= PH_POLL;
              st <= ST_MRD;
            end else begin
              reg_a <= reg_a + 1'b1;
              ph    <= (left == '0) ? PH_CMD : PH_DATA;
              st    <= ST_RRD;
            end
          end
        end
        ST_RRD: if (rom_req_ready) st <= ST_RRD_W;
        ST_RRD_W: begin
          if (rom_rsp_valid) begin
            st <= ST_RRD;
            unique case (ph)
              PH_PTR: begin
                if (is_blank(rom_rsp_data)) begin
                  err_q <= 1'b1; done_q <= 1'b1; st <= ST_DONE;
                end else begin
                  rom_a <= ADDR_W'(rom_rsp_data) + 1'b1;
                  ph    <= PH_ID;
                end
              end
              PH_ID: begin
                if (rom_rsp_data == LIST_STOP) begin
                  ns_q <= 1'b1; done_q <= 1'b1; st <= ST_DONE;
                end else if (rom_rsp_data == mtype_q) begin
                  rom_a <= rom_a + 1'b1;
                  ph    <= PH_OFS;
                end else begin
                  rom_a <= rom_a + ADDR_W'(2);
                end
              end
              PH_OFS: begin
                if (is_blank(rom_rsp_data)) begin
                  ns_q <= 1'b1; done_q <= 1'b1; st <= ST_DONE;
                end else begin
                  rom_a <= ADDR_W'(rom_rsp_data) + 1'b1;
                  ph    <= PH_CMD;
                end
              end
              PH_CMD: begin
                rom_a <= rom_a + 1'b1;
                unique case (op)
                  OP_WAIT:   st <= ST_DLY;
                  OP_BURST: begin left <= arg; ph <= PH_REG; end
                  OP_GOON:   ph <= PH_CMD;
                  OP_FINISH: begin done_q <= 1'b1; st <= ST_DONE; end
                  default:   begin err_q <= 1'b1; done_q <= 1'b1; st <= ST_DONE; end
                endcase
              end
              PH_REG: begin
                reg_a <= ADDR_W'(rom_rsp_data);
                rom_a <= rom_a + 1'b1;
                ph    <= (left == '0) ? PH_CMD : PH_DATA;
              end
              PH_DATA: begin
                wdata_q <= rom_rsp_data;
                left    <= left - 1'b1;
                rom_a   <= rom_a + 1'b1;
                st      <= ST_MWR;
              end
              default: begin err_q <= 1'b1; done_q <= 1'b1; st <= ST_DONE; end
            endcase
          end
        end
        ST_DLY: begin
          if (tmr_expired) begin
            ph <= PH_CMD;
            st <= ST_RRD;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R13: ROM request held until accepted
  p_rom_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rom_req_valid && !rom_req_ready |=> rom_req_valid && $stable(rom_addr));
  // R13: management request held until accepted
  p_mgmt_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_req_valid && !mgmt_req_ready |=> mgmt_req_valid && $stable(mgmt_addr)
      && $stable(mgmt_write) && $stable(mgmt_wdata));
  // R13: one outstanding request at a time
  p_one_req_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_req_valid, mgmt_req_valid}));
  // R2: the reset write carries the reset bit
  p_rst_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_req_valid && mgmt_write && ph == PH_CAP |-> mgmt_wdata[RST_BIT] && mgmt_addr == PHY_CTRL_REG);
  // R3: poll count stays within its bound
  p_poll_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    poll_cnt < POLL_W'(POLL_MAX));
  // R11: the two fault flags never coexist
  p_flags_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(error && not_supported));
  // R12: a finished block is quiet on both ports
  p_quiet_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rom_req_valid && !mgmt_req_valid);
  // R12: an accepted start clears the outcome
  p_start_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    start && (st == ST_IDLE || st == ST_DONE) |=> !done && !error && !not_supported);
  // R9: no port activity while waiting
  p_wait_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_DLY |-> !rom_req_valid && !mgmt_req_valid);
endmodule

// File: tb/phyinit_engine_test.sv
`timescale 1ns/1ps
module phyinit_engine_test;
  localparam int CLK_HZ = 8000;
  localparam int PER    = CLK_HZ / 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  module_type = '0;
  logic        done, error, not_supported;
  logic        rom_req_valid, rom_req_ready = 1'b0, rom_rsp_valid = 1'b0;
  logic [15:0] rom_addr, rom_rsp_data = '0;
  logic        mgmt_req_valid, mgmt_req_ready = 1'b0, mgmt_write, mgmt_rsp_valid = 1'b0;
  logic [15:0] mgmt_addr, mgmt_wdata, mgmt_rsp_data = '0;

  always #2.5 clk = ~clk;

  phyinit_engine #(.CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .module_type(module_type),
    .done(done), .error(error), .not_supported(not_supported),
    .rom_req_valid(rom_req_valid), .rom_req_ready(rom_req_ready), .rom_addr(rom_addr),
    .rom_rsp_valid(rom_rsp_valid), .rom_rsp_data(rom_rsp_data),
    .mgmt_req_valid(mgmt_req_valid), .mgmt_req_ready(mgmt_req_ready),
    .mgmt_write(mgmt_write), .mgmt_addr(mgmt_addr), .mgmt_wdata(mgmt_wdata),
    .mgmt_rsp_valid(mgmt_rsp_valid), .mgmt_rsp_data(mgmt_rsp_data)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;
  logic [15:0] rom [0:255];
  int stall = 0, clr_n = 0, ctrl_reads = 0, rom_reads = 0, nwr = 0, t_c1 = 0, t_c2 = 0;
  logic [15:0] phy_ctrl = 16'h2040, ctrl_wr = '0;
  logic [15:0] log_reg [0:15];
  logic [15:0] log_dat [0:15];
  logic rom_pend = 0, m_pend = 0;
  logic [7:0]  rom_pa = '0;
  logic [15:0] m_pdata = '0;

  always @(posedge clk) cyc <= cyc + 1;

  // Port models: decide acceptance at the falling edge, answer one cycle later
  always @(negedge clk) begin
    rom_rsp_valid = 1'b0;
    if (rom_pend) begin
      rom_rsp_valid = 1'b1; rom_rsp_data = rom[rom_pa]; rom_pend = 0;
    end
    rom_req_ready = (stall == 0) || (cyc % 3 != 0);
    if (rom_req_valid && rom_req_ready) begin
      rom_pend = 1; rom_pa = rom_addr[7:0]; rom_reads++;
      if (rom_addr == 16'h00C1) t_c1 = cyc;
      if (rom_addr == 16'h00C2) t_c2 = cyc;
    end
    mgmt_rsp_valid = 1'b0;
    if (m_pend) begin
      mgmt_rsp_valid = 1'b1; mgmt_rsp_data = m_pdata; m_pend = 0;
    end
    mgmt_req_ready = (stall == 0) || (cyc % 3 != 1);
    if (mgmt_req_valid && mgmt_req_ready) begin
      if (mgmt_write) begin
        if (mgmt_addr == 16'h0000) begin
          phy_ctrl = mgmt_wdata; ctrl_wr = mgmt_wdata;
        end else if (nwr < 16) begin
          log_reg[nwr] = mgmt_addr; log_dat[nwr] = mgmt_wdata; nwr++;
        end else nwr++;
      end else begin
        if (mgmt_addr == 16'h0000) begin
          ctrl_reads++;
          if (ctrl_reads - 1 > clr_n) phy_ctrl[15] = 1'b0;
          m_pdata = phy_ctrl;
        end else m_pdata = 16'h0000;
        m_pend = 1;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int remap(input int t);
    if (t == 5 || t == 7) return 3;
    if (t == 6 || t == 8) return 4;
    return t;
  endfunction

  // 0 = clean finish, 1 = error, 2 = not supported
  function automatic int exp_outcome(input int t);
    case (remap(t))
      1, 3, 11: return 0;
      9, 10:    return 1;
      default:  return 2;
    endcase
  endfunction

  function automatic int exp_writes(input int t);
    return (remap(t) == 1) ? 4 : 0;
  endfunction

  task automatic run(input int t, input int st);
    int w;
    stall = st; ctrl_reads = 0; rom_reads = 0; nwr = 0; phy_ctrl = 16'h2040; ctrl_wr = '0;
    @(negedge clk); start = 1'b1; module_type = 8'(t);
    @(negedge clk); start = 1'b0;
    w = 0;
    while (!done && w < 20000) begin @(negedge clk); w++; end
    if (!done) chk("R12", "run timed out", 0, 1);
  endtask

  function automatic int outcome();
    return error ? 1 : (not_supported ? 2 : 0);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) rom[i] = 16'h0000;
    rom[8'h10] = 16'h0040;
    rom[8'h41] = 16'd1;  rom[8'h42] = 16'h0060;
    rom[8'h43] = 16'd3;  rom[8'h44] = 16'h0080;
    rom[8'h45] = 16'd4;  rom[8'h46] = 16'h0000;
    rom[8'h47] = 16'd9;  rom[8'h48] = 16'h00A0;
    rom[8'h49] = 16'd10; rom[8'h4A] = 16'h00B0;
    rom[8'h4B] = 16'd11; rom[8'h4C] = 16'h00C0;
    rom[8'h4D] = 16'd12; rom[8'h4E] = 16'hFFFF;
    rom[8'h4F] = 16'hFFFF;
    rom[8'h60] = 16'h1234; rom[8'h61] = 16'h1003; rom[8'h62] = 16'h0010;
    rom[8'h63] = 16'hA500; rom[8'h64] = 16'hA501; rom[8'h65] = 16'hA502;
    rom[8'h66] = 16'hF000; rom[8'h67] = 16'h1001; rom[8'h68] = 16'h0020;
    rom[8'h69] = 16'hA503; rom[8'h6A] = 16'h0001; rom[8'h6B] = 16'hFFFF;
    rom[8'h80] = 16'h5555; rom[8'h81] = 16'h1000; rom[8'h82] = 16'h0030; rom[8'h83] = 16'hFFFF;
    rom[8'hA0] = 16'h0BAD; rom[8'hA1] = 16'h3005;
    rom[8'hB0] = 16'h0BAD; rom[8'hB1] = 16'hF123;
    rom[8'hC0] = 16'h0BAD; rom[8'hC1] = 16'h0003; rom[8'hC2] = 16'hFFFF;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "done after reset", done, 0);
    chk("R1", "flags after reset", {error, not_supported}, 0);
    chk("R1", "requests after reset", {rom_req_valid, mgmt_req_valid}, 0);

    // Main block: bursts, continue word, delay, end word
    clr_n = 2;
    run(1, 0);
    chk("R2", "reset write value", ctrl_wr, 16'hA040);
    chk("R2", "poll reads", ctrl_reads - 1, 3);
    chk("R11", "type 1 outcome", outcome(), 0);
    chk("R10", "type 1 write count", nwr, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R10", "write address", log_reg[i], (i < 3) ? 16'h0010 + i : 16'h0020);
      chk("R10", "write data", log_dat[i], 16'hA500 + i);
    end

    // Zero-length burst, check word skipped
    run(3, 0);
    chk("R8", "type 3 outcome", outcome(), 0);
    chk("R10", "zero burst writes", nwr, 0);

    // Delay timing
    clr_n = 0;
    run(11, 0);
    chk("R11", "type 11 outcome", outcome(), 0);
    chk("R9", "delay lower bound", (t_c2 - t_c1 >= 3 * PER) ? 1 : 0, 1);
    chk("R9", "delay upper bound", (t_c2 - t_c1 <= 3 * PER + 6) ? 1 : 0, 1);

    // Sweep all module types, with and without back-pressure
    for (int s = 0; s < 2; s++) begin
      for (int t = 0; t <= 12; t++) begin
        clr_n = t % 3;
        run(t, s);
        chk((remap(t) != t) ? "R7" : "R5", $sformatf("type %0d stall %0d outcome", t, s),
            outcome(), exp_outcome(t));
        chk((exp_outcome(t) == 2) ? "R6" : "R10", $sformatf("type %0d writes", t), nwr, exp_writes(t));
        chk("R13", "done after sweep run", done, 1);
      end
    end

    // Unusable pointers
    rom[8'h10] = 16'h0000; run(1, 0);
    chk("R4", "zero pointer", outcome(), 1);
    rom[8'h10] = 16'hFFFF; run(1, 0);
    chk("R4", "blank pointer", outcome(), 1);
    rom[8'h10] = 16'h0040;

    // Reset never completes
    clr_n = 1000;
    run(1, 0);
    chk("R3", "timeout outcome", outcome(), 1);
    chk("R3", "poll count", ctrl_reads - 1, 100);
    chk("R3", "no ROM access", rom_reads, 0);
    clr_n = 1;

    // Start clears flags; a second start mid-run is ignored
    run(9, 0);
    chk("R11", "bad kind outcome", outcome(), 1);
    stall = 0; ctrl_reads = 0; nwr = 0; phy_ctrl = 16'h2040;
    @(negedge clk); start = 1'b1; module_type = 8'd1;
    @(negedge clk); start = 1'b0;
    chk("R12", "flags cleared by start", {done, error, not_supported}, 0);
    repeat (5) @(negedge clk);
    start = 1'b1; module_type = 8'd9;
    @(negedge clk); start = 1'b0;
    begin
      int w = 0;
      while (!done && w < 20000) begin @(negedge clk); w++; end
    end
    chk("R12", "ignored start outcome", outcome(), 0);
    chk("R12", "ignored start writes", nwr, 4);
    repeat (4) @(negedge clk);
    chk("R12", "outcome held", {done, error, not_supported}, 3'b100);

    finished = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule